// File: doc/BRIEF.md
# Dual-Channel Transmit Configuration Latch Bank

This block holds the transmit set-up bits for two serial channels behind a single-bit write port. Software selects a channel and a latch address, then strobes one data bit. The latches drive the channel controls directly: the reference-clock source, the PLL multiplier choice, the built-in self-test disable, and the two serial driver enables. From these bits the block also derives a channel power-down, a phase-buffer bypass, a dual-edge capture request and a flag for a reserved rate and speed setting.

Each channel also has a self-clearing phase-buffer re-centre bit. Writing it low raises a request that crosses into that channel's own transmit clock through a two-flop synchroniser. An edge detector there produces one pulse. The synchronised level is carried back into the configuration clock, and the bit then returns high without any further write.

Top module: `txcfg_latch_bank`

## Requirements
- R1: After reset, every channel reads src_refclk=1, pll_x20=0, bist_off=1, drv1_en=0, drv2_en=0, and no pab_recenter pulse appears.
- R2: A write is taken when wr_en=1 at a rising clk edge. wr_chan selects the channel (0 = A, 1 = B). wr_addr selects the latch: 0 = src_refclk, 1 = pll_x20, 2 = bist_off, 3 = drv1_en, 4 = drv2_en, 5 = re-centre. The written latch shows wr_data from the next cycle on.
- R3: Writes to addresses 6 and 7 change no output.
- R4: A write to one channel leaves every output of the other channel unchanged.
- R5: chan_pdn of a channel is 1 exactly when both drv1_en and drv2_en of that channel are 0.
- R6: pab_bypass of a channel equals its src_refclk latch.
- R7: dual_edge_cap of a channel is 1 exactly when both src_refclk and pll_x20 are 1.
- R8: rate_spd_err of a channel is 1 exactly when pll_x20 is 1 and that channel's spd_sel input is 0.
- R9: pll_x20 exports the rate latch as one bit: 0 requests the x10 multiplier and 1 requests the x20 multiplier.
- R10: Writing 0 to address 5 of a channel makes exactly one pab_recenter pulse, one tx_clk cycle wide, in that channel's tx_clk domain. The bit then clears itself, so a later 0-write yields another pulse. Writing 1 to address 5 makes no pulse.
- R11: rst_n sampled low forces drv1_en and drv2_en of both channels to 0 from the next clk edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Configuration clock |
| rst_n | input | 1 | Active-low reset, sampled on clk; also clears transmit-domain flops |
| wr_en | input | 1 | Write strobe |
| wr_chan | input | CHW | Channel select, 0 = A, 1 = B |
| wr_addr | input | AW | Latch address |
| wr_data | input | 1 | Bit to write |
| spd_sel | input | NCH | Per-channel speed-select level |
| tx_clk | input | NCH | Per-channel transmit clock |
| src_refclk | output | NCH | Reference clock chosen as input-register clock |
| pll_x20 | output | NCH | PLL multiplier select (0 = x10, 1 = x20) |
| bist_off | output | NCH | Transmit self-test disabled |
| drv1_en | output | NCH | Primary serial driver enable |
| drv2_en | output | NCH | Secondary serial driver enable |
| chan_pdn | output | NCH | Channel power-down |
| pab_bypass | output | NCH | Phase alignment buffer bypass |
| dual_edge_cap | output | NCH | Capture input data on both reference edges |
| rate_spd_err | output | NCH | Reserved rate/speed combination |
| pab_recenter | output | NCH | One-cycle re-centre pulse in tx_clk domain |

## Verification
The bench runs two transmit clocks that are unrelated to the configuration clock. It counts re-centre pulses per channel and measures their width. A missing handshake return would leave the bit stuck low, so the second 0-write would give no pulse. A missing edge detect would produce a pulse many cycles wide. Writes to addresses 6 and 7, and writes aimed at one channel, are checked against the untouched outputs, which catches a loose address decode or a channel-select decode that lets one channel's writes reach the other. Toggling spd_sel while the x20 rate is set exposes a reserved-combination flag that reads the wrong polarity, and a reset in the middle of the run with both drivers on shows whether the enables really drop.

// File: rtl/txcfg_latch_bank.sv
module txcfg_latch_bank #(
  parameter int NCH = 2,
  parameter int CHW = 1,
  parameter int AW  = 3
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wr_en,
  input  logic [CHW-1:0] wr_chan,
  input  logic [AW-1:0]  wr_addr,
  input  logic           wr_data,
  input  logic [NCH-1:0] spd_sel,
  input  logic [NCH-1:0] tx_clk,
  output logic [NCH-1:0] src_refclk,
  output logic [NCH-1:0] pll_x20,
  output logic [NCH-1:0] bist_off,
  output logic [NCH-1:0] drv1_en,
  output logic [NCH-1:0] drv2_en,
  output logic [NCH-1:0] chan_pdn,
  output logic [NCH-1:0] pab_bypass,
  output logic [NCH-1:0] dual_edge_cap,
  output logic [NCH-1:0] rate_spd_err,
  output logic [NCH-1:0] pab_recenter
);
  localparam logic [AW-1:0] A_SRC  = AW'(0);
  localparam logic [AW-1:0] A_RATE = AW'(1);
  localparam logic [AW-1:0] A_BIST = AW'(2);
  localparam logic [AW-1:0] A_DRV1 = AW'(3);
  localparam logic [AW-1:0] A_DRV2 = AW'(4);
  localparam logic [AW-1:0] A_PAB  = AW'(5);

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    logic       src_q, rate_q, bist_q, drv1_q, drv2_q, pab_q;
    logic [1:0] ack_s;
    logic [2:0] tx_s;
    logic       sel;

    assign sel = wr_en && (wr_chan == CHW'(g));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        src_q  <= 1'b1;
        rate_q <= 1'b0;
        bist_q <= 1'b1;
        drv1_q <= 1'b0;
        drv2_q <= 1'b0;
        pab_q  <= 1'b1;
      end else begin
        if (sel && wr_addr == A_SRC)  src_q  <= wr_data;
        if (sel && wr_addr == A_RATE) rate_q <= wr_data;
        if (sel && wr_addr == A_BIST) bist_q <= wr_data;
        if (sel && wr_addr == A_DRV1) drv1_q <= wr_data;
        if (sel && wr_addr == A_DRV2) drv2_q <= wr_data;
        if (sel && wr_addr == A_PAB)  pab_q  <= wr_data;
        else if (!pab_q && ack_s[1])  pab_q  <= 1'b1;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ack_s <= '0;
      else        ack_s <= {ack_s[0], tx_s[1]};
    end

    always_ff @(posedge tx_clk[g] or negedge rst_n) begin
      if (!rst_n) tx_s <= '0;
      else        tx_s <= {tx_s[1:0], ~pab_q};
    end

    assign src_refclk[g]    = src_q;
    assign pll_x20[g]       = rate_q;
    assign bist_off[g]      = bist_q;
    assign drv1_en[g]       = drv1_q;
    assign drv2_en[g]       = drv2_q;
    assign chan_pdn[g]      = ~(drv1_q | drv2_q);
    assign pab_bypass[g]    = src_q;
    assign dual_edge_cap[g] = src_q & rate_q;
    assign rate_spd_err[g]  = rate_q & ~spd_sel[g];
    assign pab_recenter[g]  = tx_s[1] & ~tx_s[2];
  end
endmodule

// File: rtl/txcfg_latch_bank_chk.sv
module txcfg_latch_bank_chk #(
  parameter int NCH = 2,
  parameter int CHW = 1,
  parameter int AW  = 3
) (
  input logic           clk,
  input logic           rst_n,
  input logic           wr_en,
  input logic [CHW-1:0] wr_chan,
  input logic [AW-1:0]  wr_addr,
  input logic           wr_data,
  input logic [NCH-1:0] spd_sel,
  input logic [NCH-1:0] tx_clk,
  input logic [NCH-1:0] src_refclk,
  input logic [NCH-1:0] pll_x20,
  input logic [NCH-1:0] bist_off,
  input logic [NCH-1:0] drv1_en,
  input logic [NCH-1:0] drv2_en,
  input logic [NCH-1:0] chan_pdn,
  input logic [NCH-1:0] pab_bypass,
  input logic [NCH-1:0] dual_edge_cap,
  input logic [NCH-1:0] rate_spd_err,
  input logic [NCH-1:0] pab_recenter
);
  // R11
  drv_reset_chk: assert property (@(posedge clk)
    !rst_n |=> (drv1_en == '0 && drv2_en == '0));

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    // R2
    drv1_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_chan == CHW'(g) && wr_addr == AW'(3)) |=> drv1_en[g] == $past(wr_data));
    // R9
    rate_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_chan == CHW'(g) && wr_addr == AW'(1)) |=> pll_x20[g] == $past(wr_data));
    // R4
    other_chan_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_chan != CHW'(g)) |=> ($stable(src_refclk[g]) && $stable(pll_x20[g]) &&
        $stable(bist_off[g]) && $stable(drv1_en[g]) && $stable(drv2_en[g])));
    // R3
    undef_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_addr >= AW'(6)) |=> ($stable(src_refclk[g]) && $stable(pll_x20[g]) &&
        $stable(bist_off[g]) && $stable(drv1_en[g]) && $stable(drv2_en[g])));
    // R10
    pulse_width_chk: assert property (@(posedge tx_clk[g]) disable iff (!rst_n)
      pab_recenter[g] |=> !pab_recenter[g]);
  end
endmodule

bind txcfg_latch_bank txcfg_latch_bank_chk #(.NCH(NCH), .CHW(CHW), .AW(AW)) chk_i (.*);

// File: tb/txcfg_latch_bank_tb_top.sv
module txcfg_latch_bank_tb_top;
  logic       clk = 0, rst_n = 0, wr_en = 0, wr_chan = 0, wr_data = 0;
  logic [2:0] wr_addr = 0;
  logic [1:0] spd_sel = 2'b11, tx_clk = 0;
  logic [1:0] src_refclk, pll_x20, bist_off, drv1_en, drv2_en, chan_pdn;
  logic [1:0] pab_bypass, dual_edge_cap, rate_spd_err, pab_recenter;

  always #2.5 clk = ~clk;
  always #3.5 tx_clk[0] = ~tx_clk[0];
  always #5.5 tx_clk[1] = ~tx_clk[1];

  txcfg_latch_bank dut_i (.*);

  int n_chk = 0, n_fail = 0;
  bit done = 0, run = 0;
  int m_src[2], m_rate[2], m_bist[2], m_d1[2], m_d2[2];
  int pcnt[2] = '{0, 0}, wide[2] = '{0, 0};
  bit prev[2] = '{0, 0};

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int c = 0; c < 2; c++) begin
        m_src[c] = 1; m_rate[c] = 0; m_bist[c] = 1; m_d1[c] = 0; m_d2[c] = 0;
      end
      run = 1;
    end else if (wr_en) begin
      case (wr_addr)
        3'd0: m_src[wr_chan]  = wr_data;
        3'd1: m_rate[wr_chan] = wr_data;
        3'd2: m_bist[wr_chan] = wr_data;
        3'd3: m_d1[wr_chan]   = wr_data;
        3'd4: m_d2[wr_chan]   = wr_data;
        default: ;
      endcase
    end
  end

  always @(posedge clk) begin
    #2;
    if (run && !done) begin
      for (int c = 0; c < 2; c++) begin
        check("R2 src_refclk", src_refclk[c], m_src[c]);
        check("R9 pll_x20", pll_x20[c], m_rate[c]);
        check("R2 bist_off", bist_off[c], m_bist[c]);
        check("R11/R2 drv1_en", drv1_en[c], m_d1[c]);
        check("R11/R2 drv2_en", drv2_en[c], m_d2[c]);
        check("R5 chan_pdn", chan_pdn[c], (m_d1[c] == 0 && m_d2[c] == 0));
        check("R6 pab_bypass", pab_bypass[c], m_src[c]);
        check("R7 dual_edge_cap", dual_edge_cap[c], (m_src[c] == 1 && m_rate[c] == 1));
        check("R8 rate_spd_err", rate_spd_err[c], (m_rate[c] == 1 && spd_sel[c] == 0));
      end
    end
  end

  for (genvar g = 0; g < 2; g++) begin : g_mon
    always @(negedge tx_clk[g]) begin
      if (pab_recenter[g]) pcnt[g]++;
      if (pab_recenter[g] && prev[g]) wide[g]++;
      prev[g] = pab_recenter[g];
    end
  end

  task automatic wr(int ch, int addr, int d);
    @(negedge clk);
    wr_en = 1; wr_chan = ch[0]; wr_addr = addr[2:0]; wr_data = d[0];
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 5);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin
    int a0, b0;
    logic [9:0] snap;
    idle(4);
    rst_n = 1;
    idle(2);
    // R1 reset values
    check("R1 src_refclk", src_refclk, 2'b11);
    check("R1 pll_x20", pll_x20, 2'b00);
    check("R1 bist_off", bist_off, 2'b11);
    check("R1 drivers", {drv1_en, drv2_en}, 0);
    idle(20);
    check("R1 no pulse A", pcnt[0], 0);
    check("R1 no pulse B", pcnt[1], 0);

    wr(0, 3, 1);
    wr(1, 4, 1);
    wr(0, 1, 1);
    spd_sel[0] = 0;
    idle(2);
    check("R8 reserved flag A", rate_spd_err[0], 1);
    spd_sel[0] = 1;
    wr(0, 0, 0);
    wr(1, 1, 1);
    wr(1, 2, 0);
    spd_sel[1] = 0;
    idle(3);
    check("R7 dual edge B", dual_edge_cap[1], 1);

    // R3 undefined addresses
    snap = {src_refclk, pll_x20, bist_off, drv1_en, drv2_en};
    wr(0, 6, 1); wr(0, 7, 0); wr(1, 6, 0); wr(1, 7, 1);
    idle(1);
    check("R3 undefined addr", {src_refclk, pll_x20, bist_off, drv1_en, drv2_en}, snap);

    // R4 channel isolation
    snap = {src_refclk, pll_x20, bist_off, drv1_en, drv2_en};
    for (int k = 0; k < 5; k++) wr(0, k, (snap[k*2] == 1'b1) ? 0 : 1);
    idle(1);
    check("R4 B untouched", {src_refclk[1], pll_x20[1], bist_off[1], drv1_en[1], drv2_en[1]},
          {snap[9], snap[7], snap[5], snap[3], snap[1]});

    for (int k = 0; k < 60; k++) begin
      int ad;
      ad = $urandom_range(0, 7);
      if (ad == 5) ad = 6;
      spd_sel = 2'($urandom);
      wr($urandom_range(0, 1), ad, $urandom_range(0, 1));
    end
    spd_sel = 2'b11;

    // R10 re-centre pulses
    a0 = pcnt[0]; b0 = pcnt[1];
    wr(0, 5, 0); idle(40);
    check("R10 one pulse A", pcnt[0], a0 + 1);
    check("R10 none on B", pcnt[1], b0);
    wr(0, 5, 0); idle(40);
    check("R10 self-clear second pulse A", pcnt[0], a0 + 2);
    wr(1, 5, 0); idle(40);
    check("R10 one pulse B", pcnt[1], b0 + 1);
    wr(1, 5, 1); idle(40);
    check("R10 write 1 no pulse B", pcnt[1], b0 + 1);
    check("R10 pulse width A", wide[0], 0);
    check("R10 pulse width B", wide[1], 0);

    // R11 reset mid-run drops drivers
    wr(0, 3, 1); wr(0, 4, 1); wr(1, 3, 1); wr(1, 4, 1);
    idle(1);
    check("R5 channels on", chan_pdn, 2'b00);
    @(negedge clk) rst_n = 0;
    @(negedge clk);
    check("R11 drivers off", {drv1_en, drv2_en}, 0);
    check("R5 powered down", chan_pdn, 2'b11);
    rst_n = 1;
    idle(30);
    check("R1 no pulse after reset", pcnt[0] + pcnt[1], a0 + b0 + 3);
    finish_run();
  end
endmodule